// File: doc/BRIEF.md
# Masked Interrupt Status Controller

This block gathers the interrupt sources of one DMA channel pair into a sticky status register. Each source arrives as a single-cycle pulse. The pulse latches a status bit, and that bit stays set until software writes a one to the matching position of a write-one-to-clear register.

An enable register masks the status. The bitwise AND of the two is the interrupt cause. A small delivery-mode register decides whether the cause reaches the single level-sensitive interrupt request line. The line stays high for as long as any enabled status bit is set, so a handler that leaves a bit uncleared is interrupted again.

The source bits sit at fixed, sparse positions:

| Bit | Source | Class |
|-----|--------|-------|
| 0 | end of block | completion |
| 1 | event write-response failure | error |
| 9 | descriptor read-response failure | error |
| 10 | data read failure | error |
| 11 | data write failure | error |
| 14 | invalid descriptor | error |
| 16 | channel reset completion | reset notice |

Every other bit position is unimplemented. Registers are reached through a plain word port: a write strobe with address and data, and a combinational read path.

Top module: `irq_status_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, the status, enable and mode registers read zero and `irq_o` is low.
- R2: A pulse on `src_evt_i[k]`, for k in {0, 1, 9, 10, 11, 14}, sets status bit k at the next rising edge. The bit stays set on later cycles until it is cleared.
- R3: A write to offset 0x108 clears every status bit whose data bit is one. Bits written as zero are unchanged. Offset 0x108 reads as zero.
- R4: If a source pulse and a clear of the same status bit occur in the same cycle, the bit remains set.
- R5: The only implemented status and enable positions are bits 0, 1, 9, 10, 11, 14 and 16. All other positions of the status register (offset 0x100) and the enable register (offset 0x110) read zero, whatever is pulsed or written.
- R6: The enable register at offset 0x110 is read/write. Status bits latch whether or not they are enabled.
- R7: The mode register sits at offset 0x004. Its low 4 bits are read/write, and its upper bits read zero.
- R8: `irq_o` is high exactly when the mode field equals 1 (wired delivery) and at least one status bit is set while its enable bit is set. It stays high until every such bit is cleared or disabled. With any other mode value it stays low.
- R9: A pulse on `rst_done_i` sets status bit 16. Bit 16 of `src_evt_i` has no effect.
- R10: Reads of any other address return zero, and writes to any other address change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 12 | Register byte offset for reads and writes |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for `addr` |
| src_evt_i | input | 32 | Single-cycle source pulses, one per status bit position |
| rst_done_i | input | 1 | Single-cycle pulse when a channel reset finishes |
| irq_o | output | 1 | Level interrupt request |

## Verification
A status bit that is lost, or that gets stuck, appears at the status offset on the first read after the event or clear cycle. With the cause enabled and wired mode selected, it also shows on `irq_o` one edge after the pulse. A wrong enable or mode value shows on `irq_o` in the cycle right after the write. Set-versus-clear priority is only visible when both hit the same bit in the same cycle, so that collision is driven on purpose, and random traffic hits it again.

// File: rtl/irq_stat_pkg.sv
package irq_stat_pkg;
   localparam int unsigned REG_W  = 32;
   localparam int unsigned OFS_W  = 12;
   localparam int unsigned MODE_W = 4;

   localparam logic [OFS_W-1:0] OFS_MODE   = 12'h004;
   localparam logic [OFS_W-1:0] OFS_STATUS = 12'h100;
   localparam logic [OFS_W-1:0] OFS_CLEAR  = 12'h108;
   localparam logic [OFS_W-1:0] OFS_ENABLE = 12'h110;

   // source positions (fixed: software decodes them)
   localparam int unsigned POS_EOB      = 0;
   localparam int unsigned POS_EV_WRESP = 1;
   localparam int unsigned POS_DESC_RD  = 9;
   localparam int unsigned POS_DATA_RD  = 10;
   localparam int unsigned POS_DATA_WR  = 11;
   localparam int unsigned POS_BAD_DESC = 14;
   localparam int unsigned POS_RST_DONE = 16;

   localparam logic [REG_W-1:0] EVT_MASK =
      (REG_W'(1) << POS_EOB)     | (REG_W'(1) << POS_EV_WRESP) |
      (REG_W'(1) << POS_DESC_RD) | (REG_W'(1) << POS_DATA_RD)  |
      (REG_W'(1) << POS_DATA_WR) | (REG_W'(1) << POS_BAD_DESC);
   localparam logic [REG_W-1:0] RST_BIT  = REG_W'(1) << POS_RST_DONE;
   localparam logic [REG_W-1:0] IMPL_MASK = EVT_MASK | RST_BIT;

   localparam logic [MODE_W-1:0] MODE_WIRED = 4'd1;

   typedef struct packed {
      logic we_mode;
      logic we_clear;
      logic we_enable;
      logic sel_mode;
      logic sel_status;
      logic sel_enable;
   } reg_sel_t;
endpackage

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
   import irq_stat_pkg::*;
#(
   parameter int unsigned ADDR_W = OFS_W
) (
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   output reg_sel_t          sel
);
   initial begin
      if (ADDR_W < OFS_W) $error("ADDR_W too small for register offsets");
   end

   logic hit_mode, hit_stat, hit_clr, hit_en;

   always_comb begin
      hit_mode = (addr == ADDR_W'(OFS_MODE));
      hit_stat = (addr == ADDR_W'(OFS_STATUS));
      hit_clr  = (addr == ADDR_W'(OFS_CLEAR));
      hit_en   = (addr == ADDR_W'(OFS_ENABLE));
      sel.we_mode    = wr_en & hit_mode;
      sel.we_clear   = wr_en & hit_clr;
      sel.we_enable  = wr_en & hit_en;
      sel.sel_mode   = hit_mode;
      sel.sel_status = hit_stat;
      sel.sel_enable = hit_en;
   end
endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
   parameter int unsigned         WIDTH = 32,
   parameter logic [WIDTH-1:0]    IMPL  = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] set_vec,
   input  logic [WIDTH-1:0] clr_vec,
   output logic [WIDTH-1:0] status_q
);
   logic [WIDTH-1:0] status_d;

   // set wins over a clear aimed at the same bit
   always_comb status_d = ((status_q & ~clr_vec) | set_vec) & IMPL;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) status_q <= '0;
      else        status_q <= status_d;
   end
endmodule

// File: rtl/irq_line_gen.sv
module irq_line_gen
   import irq_stat_pkg::*;
#(
   parameter int unsigned WIDTH   = 32,
   parameter bit          REG_OUT = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WIDTH-1:0]  status,
   input  logic [WIDTH-1:0]  enable,
   input  logic [MODE_W-1:0] mode,
   output logic              irq
);
   logic cause_any;
   assign cause_any = (mode == MODE_WIRED) && ((status & enable) != '0);

   generate
      if (REG_OUT) begin : g_reg
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= cause_any;
         end
         assign irq = irq_q;
      end else begin : g_comb
         assign irq = cause_any;
      end
   endgenerate
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
   import irq_stat_pkg::*;
#(
   parameter int unsigned ADDR_W  = OFS_W,
   parameter int unsigned DATA_W  = REG_W,
   parameter bit          REG_OUT = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic [DATA_W-1:0] src_evt_i,
   input  logic              rst_done_i,
   output logic              irq_o
);
   localparam logic [DATA_W-1:0] IMPL_W = DATA_W'(IMPL_MASK);
   localparam logic [DATA_W-1:0] EVT_W  = DATA_W'(EVT_MASK);
   localparam logic [DATA_W-1:0] RST_W  = DATA_W'(RST_BIT);

   initial begin
      if (DATA_W != REG_W) $error("DATA_W must equal the register width");
      if (DATA_W <= POS_RST_DONE) $error("DATA_W cannot hold all sources");
   end

   reg_sel_t          sel;
   logic [DATA_W-1:0] status_q, enable_q, set_vec, clr_vec;
   logic [MODE_W-1:0] mode_q;

   irq_reg_decode #(.ADDR_W(ADDR_W)) u_dec (
      .wr_en (wr_en),
      .addr  (addr),
      .sel   (sel)
   );

   assign set_vec = (src_evt_i & EVT_W) | (rst_done_i ? RST_W : '0);
   assign clr_vec = sel.we_clear ? wdata : '0;

   irq_status_bank #(.WIDTH(DATA_W), .IMPL(IMPL_W)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_vec  (set_vec),
      .clr_vec  (clr_vec),
      .status_q (status_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         enable_q <= '0;
         mode_q   <= '0;
      end else begin
         if (sel.we_enable) enable_q <= wdata & IMPL_W;
         if (sel.we_mode)   mode_q   <= wdata[MODE_W-1:0];
      end
   end

   always_comb begin
      rdata = '0;
      if (sel.sel_status) rdata = status_q;
      if (sel.sel_enable) rdata = enable_q;
      if (sel.sel_mode)   rdata = DATA_W'(mode_q);
   end

   irq_line_gen #(.WIDTH(DATA_W), .REG_OUT(REG_OUT)) u_line (
      .clk    (clk),
      .rst_n  (rst_n),
      .status (status_q),
      .enable (enable_q),
      .mode   (mode_q),
      .irq    (irq_o)
   );
endmodule

// File: rtl/irq_status_ctrl_chk.sv
module irq_status_ctrl_chk
   import irq_stat_pkg::*;
#(
   parameter int unsigned ADDR_W  = OFS_W,
   parameter int unsigned DATA_W  = REG_W,
   parameter bit          REG_OUT = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] addr,
   input logic [DATA_W-1:0] wdata,
   input logic [DATA_W-1:0] src_evt_i,
   input logic              rst_done_i,
   input logic [DATA_W-1:0] status_q,
   input logic [DATA_W-1:0] enable_q,
   input logic [MODE_W-1:0] mode_q,
   input logic              irq_o
);
   localparam logic [DATA_W-1:0] EVT_W = DATA_W'(EVT_MASK);
   localparam logic [DATA_W-1:0] RST_W = DATA_W'(RST_BIT);

   logic past_ok;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   logic [DATA_W-1:0] pulse_vec;
   logic              clr_wr;
   assign pulse_vec = (src_evt_i & EVT_W) | (rst_done_i ? RST_W : '0);
   assign clr_wr    = wr_en && (addr == ADDR_W'(OFS_CLEAR));

   // R2, R4, R9: a pulsed source is set on the next edge, even against a clear
   assert_pulse_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok |-> ((status_q & $past(pulse_vec)) == $past(pulse_vec)));

   // R3: cleared bits fall unless re-pulsed
   assert_clear_drops_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $past(clr_wr)) |->
         ((status_q & $past(wdata) & ~$past(pulse_vec)) == '0));

   // R2: without a clear write no status bit falls
   assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && !$past(clr_wr)) |-> ((status_q & $past(status_q)) == $past(status_q)));

   generate
      if (!REG_OUT) begin : g_comb_chk
         // R8: line follows the enabled cause in wired mode only
         assert_line_wired_R8: assert property (@(posedge clk) disable iff (!rst_n)
            ((mode_q == MODE_WIRED) && ((status_q & enable_q) != '0)) |-> irq_o);
         assert_line_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
            ((mode_q != MODE_WIRED) || ((status_q & enable_q) == '0)) |-> !irq_o);
      end else begin : g_reg_chk
         assert_line_wired_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (past_ok && $past(mode_q) == MODE_WIRED && $past(status_q & enable_q) != '0)
               |-> irq_o);
      end
   endgenerate
endmodule

bind irq_status_ctrl irq_status_ctrl_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_OUT(REG_OUT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
   .src_evt_i(src_evt_i), .rst_done_i(rst_done_i), .status_q(status_q),
   .enable_q(enable_q), .mode_q(mode_q), .irq_o(irq_o)
);

// File: tb/irq_status_ctrl_test.sv
module irq_status_ctrl_test;
   localparam logic [31:0] IMPL = 32'h0001_4E03;
   localparam logic [31:0] EVTS = 32'h0000_4E03;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [11:0] addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [31:0] src_evt_i = '0;
   logic        rst_done_i = 1'b0;
   logic        irq_o;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   logic [31:0] exp_st = '0, exp_en = '0;
   logic [3:0]  exp_mode = '0;

   always #4 clk = ~clk;

   irq_status_ctrl uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .rdata(rdata), .src_evt_i(src_evt_i), .rst_done_i(rst_done_i), .irq_o(irq_o)
   );

   function automatic logic exp_irq();
      return (exp_mode == 4'd1) && ((exp_st & exp_en) != 0);
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // one cycle of stimulus, model update, line check
   task automatic cyc(string req, logic w, logic [11:0] a, logic [31:0] d,
                      logic [31:0] ev, logic rd);
      @(negedge clk);
      wr_en = w; addr = a; wdata = d; src_evt_i = ev; rst_done_i = rd;
      @(posedge clk);
      if (w && a == 12'h110) exp_en = d & IMPL;
      if (w && a == 12'h004) exp_mode = d[3:0];
      exp_st = ((exp_st & ~((w && a == 12'h108) ? d : 32'h0)) |
                (ev & EVTS) | (rd ? 32'h0001_0000 : 32'h0)) & IMPL;
      #1;
      check(req, {31'b0, irq_o}, {31'b0, exp_irq()});
   endtask

   task automatic rd_chk(string req, logic [11:0] a, logic [31:0] exp);
      @(negedge clk);
      wr_en = 0; addr = a; wdata = '0; src_evt_i = '0; rst_done_i = 0;
      #1;
      check(req, rdata, exp);
      @(posedge clk);
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(posedge clk);
      #1;
      check("R1 irq in reset", {31'b0, irq_o}, 32'h0);
      @(negedge clk); rst_n = 1;
      rd_chk("R1 status", 12'h100, 32'h0);
      rd_chk("R1 enable", 12'h110, 32'h0);
      rd_chk("R1 mode",   12'h004, 32'h0);

      cyc("R7 mode write", 1, 12'h004, 32'hFFFF_FFF1, 0, 0);
      rd_chk("R7 mode upper zero", 12'h004, 32'h1);
      cyc("R6 enable write", 1, 12'h110, 32'hFFFF_FFFF, 0, 0);
      rd_chk("R5 enable implemented only", 12'h110, IMPL);
      cyc("R6 disable all", 1, 12'h110, 32'h0, 0, 0);
      cyc("R2 all pulses", 0, 12'h000, 0, 32'hFFFF_FFFF, 0);
      rd_chk("R5 R9 status after all pulses", 12'h100, EVTS);
      rd_chk("R6 latched while disabled, irq low", 12'h000, 32'h0);
      cyc("R8 enable raises line", 1, 12'h110, 32'h0000_0001, 0, 0);
      check("R8 line high", {31'b0, irq_o}, 32'h1);
      cyc("R9 reset done", 0, 12'h000, 0, 0, 1);
      rd_chk("R9 bit 16 set", 12'h100, EVTS | 32'h0001_0000);
      cyc("R4 set with clear", 1, 12'h108, 32'h0000_0001, 32'h0000_0001, 0);
      rd_chk("R4 bit0 kept", 12'h100, EVTS | 32'h0001_0000);
      cyc("R3 partial clear", 1, 12'h108, 32'h0001_0E00, 0, 0);
      rd_chk("R3 partial result", 12'h100, 32'h0000_4003);
      check("R8 still high", {31'b0, irq_o}, 32'h1);
      cyc("R8 mode 2 quiet", 1, 12'h004, 32'h2, 0, 0);
      check("R8 line low mode2", {31'b0, irq_o}, 32'h0);
      cyc("R8 back wired", 1, 12'h004, 32'h1, 0, 0);
      cyc("R10 stray write", 1, 12'h20C, 32'hFFFF_FFFF, 0, 0);
      rd_chk("R10 stray read", 12'h20C, 32'h0);
      rd_chk("R3 clear reg reads zero", 12'h108, 32'h0);
      rd_chk("R10 status unchanged", 12'h100, 32'h0000_4003);
      cyc("R3 clear all", 1, 12'h108, 32'hFFFF_FFFF, 0, 0);
      rd_chk("R3 status empty", 12'h100, 32'h0);
      check("R8 line low after clear", {31'b0, irq_o}, 32'h0);

      for (int i = 0; i < 600; i++) begin
         logic [11:0] a;
         logic [31:0] d, ev;
         case ($urandom % 5)
            0: a = 12'h004; 1: a = 12'h100; 2: a = 12'h108;
            3: a = 12'h110; default: a = 12'h20C;
         endcase
         d  = $urandom;
         if (a == 12'h004) d[3:0] = ($urandom % 2) ? 4'd1 : d[3:0];
         ev = $urandom & $urandom & $urandom;
         cyc("R2 R3 R4 R8 random", ($urandom % 3) == 0, a, d, ev, ($urandom % 9) == 0);
         if (i % 8 == 7) begin
            rd_chk("R2 R5 random status", 12'h100, exp_st);
            rd_chk("R6 random enable", 12'h110, exp_en);
         end
      end

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule